// File: doc/BRIEF.md
# Serial Boot Handshake Sequencer

This block runs the byte-level exchange that loads a program over a serial link once the receiver has locked onto the host's bit rate. It waits for a sync byte, answers it, takes a two-byte program length, then takes that many program bytes. Every byte it accepts after sync is echoed to the host, and each program byte is also written into on-chip RAM at consecutive addresses. After the last byte it asks the flash controller to check and clear the flash array. It then reports success or failure to the host with a single status byte.

On success the block raises a level that tells the rest of the chip to start executing the loaded image. On failure it sends an error code and locks up until reset. The UART and the flash controller sit outside the block. The receive side is a plain valid/data stream with no back-pressure: the host is expected to wait for each echo before it sends the next byte. A byte that arrives while a reply is still waiting is dropped.

Top module: `boot_seq`

## Requirements
- R1: After reset, tx_valid, ram_we, erase_req and run_ram are all low, and the block waits for sync.
- R2: While waiting for sync, a received 0x55 makes the block offer 0xAA on the transmit stream one cycle after the byte is sampled.
- R3: While waiting for sync, a received byte other than 0x55 produces no transmit and no RAM write, and a later 0x55 is still answered.
- R4: The two bytes after sync are the program length N, high byte first. Each is echoed unchanged one cycle after it is sampled.
- R5: Each of the N program bytes is echoed one cycle after it is sampled. In that same cycle, ram_we pulses high for exactly one cycle with ram_wdata equal to the byte.
- R6: The first program byte is written at address RAM_BASE, and each following byte is written one address higher.
- R7: erase_req rises on the clock edge where the transmitter accepts the echo of the last program byte. It stays high until the flash controller answers, and no RAM write happens while it is high.
- R8: A length of zero writes nothing. erase_req rises on the edge where the echo of the low length byte is accepted.
- R9: A one-cycle erase_done makes 0xAA appear on the transmit stream one cycle later and drops erase_req. run_ram goes high on the edge where that 0xAA is accepted and stays high.
- R10: A one-cycle erase_fail makes 0xFF appear on the transmit stream one cycle later and drops erase_req. After that, received bytes are ignored and run_ram never rises until reset.
- R11: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.
- R12: A byte received while tx_valid is high is discarded. It is not echoed, not written, and not counted toward N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_data | output | 8 | Byte to transmit |
| ram_we | output | 1 | RAM write strobe, one cycle per program byte |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| erase_req | output | 1 | Request a full flash check and erase |
| erase_done | input | 1 | Erase finished without error (one-cycle pulse) |
| erase_fail | input | 1 | Erase could not complete (one-cycle pulse) |
| run_ram | output | 1 | Start execution of the image in RAM |

## Verification
Every reply to a received byte or to an erase answer comes from a register, so it is due exactly one cycle after the stimulus is sampled. The bench drives each input on a falling edge and reads the response on the next falling edge. erase_req and run_ram follow the handshake edge that accepts the preceding echo, so the bench checks them on the falling edge right after it pulses tx_ready. The write strobe is checked both in its one active cycle and in the cycle after, which confirms that it lasts a single cycle.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   localparam int BYTE_W = 8;
   localparam int LEN_W  = 2 * BYTE_W;

   localparam logic [BYTE_W-1:0] SYNC_REQ  = 8'h55;
   localparam logic [BYTE_W-1:0] SYNC_ACK  = 8'hAA;
   localparam logic [BYTE_W-1:0] ERASE_BAD = 8'hFF;

   typedef enum logic [3:0] {
      ST_SYNC   = 4'd0,
      ST_LEN_HI = 4'd1,
      ST_LEN_LO = 4'd2,
      ST_LOAD   = 4'd3,
      ST_DRAIN  = 4'd4,
      ST_ERASE  = 4'd5,
      ST_REPORT = 4'd6,
      ST_RUN    = 4'd7,
      ST_ABORT  = 4'd8
   } boot_st_e;

endpackage

// File: rtl/boot_tx_slot.sv
module boot_tx_slot #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_byte,
   input  logic          ready,
   output logic          valid,
   output logic [DW-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_byte;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/boot_len_ctr.sv
module boot_len_ctr #(
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] load_val,
   input  logic          dec,
   output logic          last
);

   logic [LW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    remain_q <= '0;
      else if (load) remain_q <= load_val;
      else if (dec)  remain_q <= remain_q - 1'b1;
   end

   assign last = (remain_q == LW'(1));

endmodule

// File: rtl/boot_addr_ptr.sv
module boot_addr_ptr #(
   parameter int             AW   = 16,
   parameter logic [AW-1:0]  BASE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [AW-1:0] addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= BASE;
      else if (step) addr <= addr + 1'b1;
   end

endmodule

// File: rtl/boot_seq.sv
module boot_seq
   import boot_seq_pkg::*;
#(
   parameter int            AW       = 16,
   parameter logic [AW-1:0] RAM_BASE = 16'h2000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_valid,
   input  logic [BYTE_W-1:0]    rx_data,
   output logic                 tx_valid,
   input  logic                 tx_ready,
   output logic [BYTE_W-1:0]    tx_data,
   output logic                 ram_we,
   output logic [AW-1:0]        ram_addr,
   output logic [BYTE_W-1:0]    ram_wdata,
   output logic                 erase_req,
   input  logic                 erase_done,
   input  logic                 erase_fail,
   output logic                 run_ram
);

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("boot_seq: AW must lie in 8..32");
      end
   endgenerate

   boot_st_e          st_q, st_d;
   logic [BYTE_W-1:0] len_hi_q;
   logic              rx_take;
   logic              tx_load;
   logic [BYTE_W-1:0] tx_byte;
   logic              wr_now;
   logic              len_load;
   logic              len_dec;
   logic              len_last;
   logic [AW-1:0]     ptr;
   logic [LEN_W-1:0]  len_full;

   assign rx_take  = rx_valid && !tx_valid;
   assign len_full = {len_hi_q, rx_data};

   always_comb begin
      st_d     = st_q;
      tx_load  = 1'b0;
      tx_byte  = rx_data;
      wr_now   = 1'b0;
      len_load = 1'b0;
      len_dec  = 1'b0;
      unique case (st_q)
         ST_SYNC: if (rx_take && rx_data == SYNC_REQ) begin
            tx_load = 1'b1;
            tx_byte = SYNC_ACK;
            st_d    = ST_LEN_HI;
         end
         ST_LEN_HI: if (rx_take) begin
            tx_load = 1'b1;
            st_d    = ST_LEN_LO;
         end
         ST_LEN_LO: if (rx_take) begin
            tx_load  = 1'b1;
            len_load = 1'b1;
            st_d     = (len_full == '0) ? ST_DRAIN : ST_LOAD;
         end
         ST_LOAD: if (rx_take) begin
            tx_load = 1'b1;
            wr_now  = 1'b1;
            len_dec = 1'b1;
            if (len_last) st_d = ST_DRAIN;
         end
         ST_DRAIN: if (!tx_valid || tx_ready) st_d = ST_ERASE;
         ST_ERASE: begin
            if (erase_fail) begin
               tx_load = 1'b1;
               tx_byte = ERASE_BAD;
               st_d    = ST_ABORT;
            end else if (erase_done) begin
               tx_load = 1'b1;
               tx_byte = SYNC_ACK;
               st_d    = ST_REPORT;
            end
         end
         ST_REPORT: if (tx_valid && tx_ready) st_d = ST_RUN;
         ST_RUN:    st_d = ST_RUN;
         ST_ABORT:  st_d = ST_ABORT;
         default:   st_d = ST_ABORT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_SYNC;
         len_hi_q  <= '0;
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
      end else begin
         st_q   <= st_d;
         ram_we <= wr_now;
         if (st_q == ST_LEN_HI && rx_take) len_hi_q <= rx_data;
         if (wr_now) begin
            ram_addr  <= ptr;
            ram_wdata <= rx_data;
         end
      end
   end

   assign erase_req = (st_q == ST_ERASE);
   assign run_ram   = (st_q == ST_RUN);

   boot_tx_slot #(.DW(BYTE_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .load_byte (tx_byte),
      .ready     (tx_ready),
      .valid     (tx_valid),
      .data      (tx_data)
   );

   boot_len_ctr #(.LW(LEN_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (len_load),
      .load_val (len_full),
      .dec      (len_dec),
      .last     (len_last)
   );

   boot_addr_ptr #(.AW(AW), .BASE(RAM_BASE)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (wr_now),
      .addr  (ptr)
   );

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
   import boot_seq_pkg::*;
#(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic [7:0]    rx_data,
   input logic          tx_valid,
   input logic          tx_ready,
   input logic [7:0]    tx_data,
   input logic          ram_we,
   input logic [AW-1:0] ram_addr,
   input logic [7:0]    ram_wdata,
   input logic          erase_req,
   input logic          run_ram,
   input boot_st_e      st
);

   logic          have_prev;
   logic [AW-1:0] prev_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_addr <= '0;
      end else if (ram_we) begin
         have_prev <= 1'b1;
         prev_addr <= ram_addr;
      end
   end

   a_r2_sync_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_data == 8'h55 && st == ST_SYNC && !tx_valid)
      |=> (tx_valid && tx_data == 8'hAA));

   a_r5_echo_matches_write: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (tx_valid && tx_data == ram_wdata));

   a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && have_prev) |-> (ram_addr == prev_addr + 1'b1));

   a_r7_erase_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (!ram_we && !tx_valid));

   a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      run_ram |=> run_ram);

   a_r10_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ABORT) |=> (st == ST_ABORT));

   a_r10_abort_no_run: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ABORT) |-> !run_ram);

   a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   a_r12_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && tx_valid) |=> !ram_we);

endmodule

bind boot_seq boot_seq_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_data   (tx_data),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .ram_wdata (ram_wdata),
   .erase_req (erase_req),
   .run_ram   (run_ram),
   .st        (st_q)
);

// File: tb/boot_seq_tb.sv
module boot_seq_tb;

   localparam int            CLK_PERIOD = 10;
   localparam int            AW         = 16;
   localparam logic [AW-1:0] BASE       = 16'h2000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_data = '0;
   logic          tx_valid;
   logic          tx_ready = 1'b0;
   logic [7:0]    tx_data;
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [7:0]    ram_wdata;
   logic          erase_req;
   logic          erase_done = 1'b0;
   logic          erase_fail = 1'b0;
   logic          run_ram;

   int n_chk = 0;
   int n_bad = 0;

   boot_seq #(.AW(AW), .RAM_BASE(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .erase_req(erase_req), .erase_done(erase_done), .erase_fail(erase_fail),
      .run_ram(run_ram)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [AW-1:0] exp_addr(input int idx);
      return BASE + AW'(idx);
   endfunction

   function automatic logic [7:0] rand_junk();
      logic [7:0] v;
      v = 8'($urandom);
      if (v == 8'h55) v = 8'h54;
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic send(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic take();
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      rx_valid = 1'b0; tx_ready = 1'b0; erase_done = 1'b0; erase_fail = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // One full session; n = length, junk = non-sync bytes first, fail = erase result, dropchk = test R12
   task automatic session(input int n, input int junk, input bit fail, input bit dropchk);
      logic [7:0] b;
      int wait_cyc;
      do_reset();
      chk(!tx_valid && !ram_we && !erase_req && !run_ram, "R1 reset outputs",
          {tx_valid, ram_we, erase_req, run_ram}, 0);
      for (int j = 0; j < junk; j++) begin
         send(rand_junk());
         chk(!tx_valid && !ram_we, "R3 junk ignored", {tx_valid, ram_we}, 0);
      end
      send(8'h55);
      chk(tx_valid && tx_data == 8'hAA, "R2 sync ack", tx_data, 8'hAA);
      wait_cyc = $urandom_range(0, 3);
      for (int k = 0; k < wait_cyc; k++) begin
         @(negedge clk);
         chk(tx_valid && tx_data == 8'hAA, "R11 hold without ready", tx_data, 8'hAA);
      end
      take();
      send(8'(n >> 8));
      chk(tx_valid && tx_data == 8'(n >> 8), "R4 echo high length", tx_data, 8'(n >> 8));
      take();
      send(8'(n));
      chk(tx_valid && tx_data == 8'(n), "R4 echo low length", tx_data, 8'(n));
      chk(!ram_we, "R8 no write on length", ram_we, 0);
      take();
      if (n == 0)
         chk(erase_req, "R8 zero length goes to erase", erase_req, 1);
      else
         chk(!erase_req, "R7 no erase before payload", erase_req, 0);
      for (int i = 0; i < n; i++) begin
         b = 8'($urandom);
         send(b);
         chk(tx_valid && tx_data == b, "R5 payload echo", tx_data, b);
         chk(ram_we && ram_wdata == b, "R5 payload write", {ram_we, ram_wdata}, {1'b1, b});
         chk(ram_addr == exp_addr(i), "R6 write address", ram_addr, exp_addr(i));
         if (dropchk && i == 0) begin
            send(~b);
            chk(tx_valid && tx_data == b && !ram_we, "R12 busy byte dropped",
                {ram_we, tx_data}, {1'b0, b});
         end
         take();
         chk(!ram_we, "R5 write strobe one cycle", ram_we, 0);
         chk(erase_req == (i == n - 1), "R7 erase request timing", erase_req, (i == n - 1));
      end
      repeat (2) @(negedge clk);
      chk(erase_req && !ram_we, "R7 erase request held", erase_req, 1);
      if (fail) erase_fail = 1'b1; else erase_done = 1'b1;
      @(negedge clk);
      erase_fail = 1'b0; erase_done = 1'b0;
      if (fail) begin
         chk(tx_valid && tx_data == 8'hFF && !erase_req, "R10 fail code", tx_data, 8'hFF);
         take();
         send(8'h55);
         chk(!tx_valid && !ram_we, "R10 input ignored after abort", tx_valid, 0);
         repeat (3) @(negedge clk);
         chk(!run_ram, "R10 never runs", run_ram, 0);
      end else begin
         chk(tx_valid && tx_data == 8'hAA && !erase_req, "R9 success code", tx_data, 8'hAA);
         chk(!run_ram, "R9 run waits for ack send", run_ram, 0);
         take();
         chk(run_ram, "R9 run raised", run_ram, 1);
         repeat (3) @(negedge clk);
         chk(run_ram, "R9 run stays high", run_ram, 1);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      session(3, 2, 1'b0, 1'b0);
      session(0, 0, 1'b0, 1'b0);
      session(0, 1, 1'b1, 1'b0);
      session(4, 0, 1'b0, 1'b1);
      session(5, 3, 1'b1, 1'b0);
      for (int s = 0; s < 8; s++)
         session($urandom_range(0, 24), $urandom_range(0, 4), 1'($urandom), 1'($urandom));
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule